// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block turns a 32-bit virtual address into a physical address for a processor pipeline. It holds 64 translation entries. On each lookup the 20-bit page number and a 6-bit address-space tag are compared against every entry at the same time. There is no index field. Entries are tagged by address space, so translations that belong to different processes can sit side by side. A context switch only changes the tag presented with each lookup, and the buffer never needs to be emptied.

The three most significant address bits pick a segment. User space and kernel virtual space go through the lookup. The two kernel physical windows bypass it: the address passes through with its top three bits cleared, and one of the two windows is flagged as uncached. A lookup that finds no entry reports a miss. A software handler then installs an entry through the refill port by giving a slot number and the entry contents. The block does not read page tables itself.

When a lookup hits, the block returns the physical page number together with the entry's modified, referenced and permission flags, and it marks the entry as referenced. A store that hits a read-only entry is reported as a protection fault.

Top module: `tlb_assoc_xlate`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0 and every entry is invalid, so a translated lookup misses.
- R2: A lookup sampled on a clock edge with `lk_req`=1 drives its result on the outputs right after that same edge, with `rsp_valid`=1. It hits only when an entry has `valid`=1, its page number equals `lk_vaddr[31:12]` and its tag equals `lk_asid`. Exactly one of `rsp_hit`, `rsp_miss` and `rsp_prot_fault` is 1 for each response.
- R3: An entry whose tag differs from `lk_asid` never hits. Two entries with the same page number and different tags each return their own physical page, depending on the tag presented.
- R4: On a translated hit, `rsp_paddr` = {entry physical page, `lk_vaddr[11:0]`}, and `rsp_dirty` and `rsp_rw` carry the entry's flags.
- R5: When several entries match, the entry with the lowest slot number supplies the result.
- R6: A non-faulting translated hit sets the entry's referenced flag. `rsp_ref` reports the flag's value as it was before this lookup, so the next hit on the same entry reports 1. A refill clears the flag.
- R7: A lookup with `lk_write`=1 that hits an entry with `rw`=0 (read-only) gives `rsp_prot_fault`=1, `rsp_hit`=0, `rsp_paddr`=0 and all flags 0, and it leaves the referenced flag unchanged. A write lookup that hits an entry with `rw`=1 is a normal hit.
- R8: Addresses with top bits 100 are unmapped: `rsp_hit`=1, `rsp_mapped`=0, `rsp_uncached`=0, `rsp_paddr` is the address with bits 31..29 cleared and all flags are 0, whatever the entries contain.
- R9: Addresses with top bits 101 behave as in R8, except that `rsp_uncached`=1.
- R10: Addresses with top bits 0xx or 11x are translated (`rsp_mapped`=1), and `rsp_uncached` is 0 for them.
- R11: A refill written on an edge is seen by a lookup sampled on the next edge. A lookup sampled on the same edge as the refill sees the old contents.
- R12: After an edge where `lk_req`=0, `rsp_valid` is 0 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space tag of the current process |
| lk_write | input | 1 | Lookup is a store |
| wr_en | input | 1 | Refill strobe |
| wr_idx | input | 6 | Slot to overwrite |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_ppn | input | 20 | Physical page number of the new entry |
| wr_asid | input | 6 | Address-space tag of the new entry |
| wr_valid | input | 1 | Valid flag of the new entry |
| wr_dirty | input | 1 | Modified flag of the new entry |
| wr_rw | input | 1 | 1 = read/write, 0 = read-only |
| rsp_valid | output | 1 | A response is on the outputs |
| rsp_hit | output | 1 | Translation delivered |
| rsp_miss | output | 1 | No matching entry |
| rsp_prot_fault | output | 1 | Store to a read-only page |
| rsp_mapped | output | 1 | Address went through the lookup |
| rsp_uncached | output | 1 | Uncached kernel physical window |
| rsp_dirty | output | 1 | Modified flag of the hit entry |
| rsp_ref | output | 1 | Referenced flag of the hit entry before this lookup |
| rsp_rw | output | 1 | Permission flag of the hit entry |
| rsp_paddr | output | 32 | Physical address |

## Verification
Every lookup result is registered once. The bench drives a request on a falling edge and reads every output 1 ns after the next rising edge. Refills and referenced-flag updates land on that same rising edge. The bench model therefore computes each expected response from the entry state held before the edge, and only then applies the write and the flag update. A refill and a lookup aimed at the same slot in one cycle are checked in that order, and the next cycle shows the new entry.

// File: rtl/tlb_pkg.sv
// Shared widths and the entry record for the translation buffer.
// Assumes a 32-bit virtual address split into page number and offset.
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int ASID_W = 6;
    localparam int SEG_W  = 3;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic              valid;
        logic              dirty;
        logic              refd;
        logic              rw;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_seg_decode.sv
// Segment decode: classifies the top address bits.
// Assumes a 3-bit field: 0xx user and 11x kernel virtual are translated,
// 100 is a cached physical window and 101 an uncached one.
module tlb_seg_decode #(
    parameter int SEG_W = 3
) (
    input  logic [SEG_W-1:0] seg_i,
    output logic             mapped_o,
    output logic             uncached_o
);
    localparam logic [1:0] PHYS_PREFIX = 2'b10;

    logic phys_win;

    // Identify the two bypass windows and pick the uncached one.
    always_comb begin
        phys_win   = (seg_i[SEG_W-1 -: 2] == PHYS_PREFIX);
        mapped_o   = !phys_win;
        uncached_o = phys_win && seg_i[SEG_W-3];
    end
endmodule

// File: rtl/tlb_entry_store.sv
// Entry storage: one register per slot, written by refill and
// flagged as referenced by hits. Assumes a refill to a slot wins
// over a referenced-flag update to the same slot in the same cycle.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_data,
    input  logic             set_ref,
    input  logic [IDX_W-1:0] set_idx,
    output tlb_entry_t       ent_o [N_ENT]
);
    tlb_entry_t ent_q [N_ENT];

    // Clear on reset, else mark referenced entries and apply refills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
        end else begin
            if (set_ref) ent_q[set_idx].refd <= 1'b1;
            if (wr_en)   ent_q[wr_idx]       <= wr_data;
        end
    end

    // Expose the stored entries to the comparators.
    always_comb begin
        for (int i = 0; i < N_ENT; i++) ent_o[i] = ent_q[i];
    end

    AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_data))); // R11

    AST_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ref && !(wr_en && wr_idx == set_idx)) |=> ent_q[$past(set_idx)].refd); // R6
endmodule

// File: rtl/tlb_cam_match.sv
// Parallel comparator bank with a lowest-slot priority pick.
// Assumes entries are stable during the cycle; purely combinational.
module tlb_cam_match
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  tlb_entry_t        ent_i [N_ENT],
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [ASID_W-1:0] asid_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [N_ENT-1:0] match;

    // One comparator per slot: valid, page and address-space tag.
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = ent_i[g].valid && (ent_i[g].vpn == vpn_i)
                          && (ent_i[g].asid == asid_i);
    end

    // Priority pick: scanning downward leaves the lowest match.
    always_comb begin
        idx_o = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
        hit_o = |match;
    end
endmodule

// File: rtl/tlb_assoc_xlate.sv
// Top: fully associative, address-space-tagged translation buffer.
// Registers one response per request; refill writes land at the same
// edge that samples a lookup, so that lookup sees the old contents.
module tlb_assoc_xlate
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_rw,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_prot_fault,
    output logic              rsp_mapped,
    output logic              rsp_uncached,
    output logic              rsp_dirty,
    output logic              rsp_ref,
    output logic              rsp_rw,
    output logic [PA_W-1:0]   rsp_paddr
);
    tlb_entry_t       ent [N_ENT];
    tlb_entry_t       wr_data;
    tlb_entry_t       sel;
    logic             seg_mapped, seg_unc;
    logic             cam_hit;
    logic [IDX_W-1:0] cam_idx;
    logic             fault, do_ref;

    // Pack the refill fields; a fresh entry starts unreferenced.
    always_comb begin
        wr_data       = '0;
        wr_data.vpn   = wr_vpn;
        wr_data.ppn   = wr_ppn;
        wr_data.asid  = wr_asid;
        wr_data.valid = wr_valid;
        wr_data.dirty = wr_dirty;
        wr_data.rw    = wr_rw;
    end

    tlb_seg_decode #(.SEG_W(SEG_W)) i_seg (
        .seg_i      (lk_vaddr[VA_W-1 -: SEG_W]),
        .mapped_o   (seg_mapped),
        .uncached_o (seg_unc)
    );

    tlb_entry_store #(.N_ENT(N_ENT)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .set_ref (do_ref),
        .set_idx (cam_idx),
        .ent_o   (ent)
    );

    tlb_cam_match #(.N_ENT(N_ENT)) i_cam (
        .ent_i  (ent),
        .vpn_i  (lk_vaddr[VA_W-1:OFF_W]),
        .asid_i (lk_asid),
        .hit_o  (cam_hit),
        .idx_o  (cam_idx)
    );

    // Select the winning entry and resolve permission.
    always_comb begin
        sel    = ent[cam_idx];
        fault  = seg_mapped && cam_hit && lk_write && !sel.rw;
        do_ref = lk_req && seg_mapped && cam_hit && !fault;
    end

    // Register the response for one cycle; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !lk_req) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_miss       <= 1'b0;
            rsp_prot_fault <= 1'b0;
            rsp_mapped     <= 1'b0;
            rsp_uncached   <= 1'b0;
            rsp_dirty      <= 1'b0;
            rsp_ref        <= 1'b0;
            rsp_rw         <= 1'b0;
            rsp_paddr      <= '0;
        end else begin
            rsp_valid      <= 1'b1;
            rsp_mapped     <= seg_mapped;
            rsp_uncached   <= seg_unc;
            rsp_prot_fault <= fault;
            if (!seg_mapped) begin
                rsp_hit   <= 1'b1;
                rsp_miss  <= 1'b0;
                rsp_dirty <= 1'b0;
                rsp_ref   <= 1'b0;
                rsp_rw    <= 1'b0;
                rsp_paddr <= {{SEG_W{1'b0}}, lk_vaddr[VA_W-SEG_W-1:0]};
            end else if (cam_hit && !fault) begin
                rsp_hit   <= 1'b1;
                rsp_miss  <= 1'b0;
                rsp_dirty <= sel.dirty;
                rsp_ref   <= sel.refd;
                rsp_rw    <= sel.rw;
                rsp_paddr <= {sel.ppn, lk_vaddr[OFF_W-1:0]};
            end else begin
                rsp_hit   <= 1'b0;
                rsp_miss  <= !cam_hit;
                rsp_dirty <= 1'b0;
                rsp_ref   <= 1'b0;
                rsp_rw    <= 1'b0;
                rsp_paddr <= '0;
            end
        end
    end

    AST_REQ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R2

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot_fault}) == 1); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_prot_fault && rsp_paddr == '0); // R12

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_fault |-> rsp_paddr == '0 && !rsp_hit && rsp_mapped); // R7

    AST_BYPASS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_mapped) |-> rsp_hit && rsp_paddr[PA_W-1 -: SEG_W] == '0); // R8

    AST_UNCACHED_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncached |-> !rsp_mapped); // R9
endmodule

// File: tb/test_tlb_assoc_xlate.sv
module test_tlb_assoc_xlate;
    logic clk = 0, rst_n = 0;
    logic lk_req = 0, lk_write = 0, wr_en = 0;
    logic [31:0] lk_vaddr = 0;
    logic [5:0] lk_asid = 0, wr_idx = 0, wr_asid = 0;
    logic [19:0] wr_vpn = 0, wr_ppn = 0;
    logic wr_valid = 0, wr_dirty = 0, wr_rw = 0;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_mapped;
    logic rsp_uncached, rsp_dirty, rsp_ref, rsp_rw;
    logic [31:0] rsp_paddr;
    int checks = 0, errors = 0;

    logic [19:0] m_vpn [64];
    logic [19:0] m_ppn [64];
    logic [5:0]  m_asid [64];
    logic        m_v [64], m_d [64], m_r [64], m_rw [64];

    always #5 clk = ~clk;

    tlb_assoc_xlate i_tlb_assoc_xlate (.*);

    // Expected response per the requirements, from model state before the edge.
    task automatic expect_rsp(input logic req, input logic [31:0] va, input logic [5:0] asid,
                              input logic wr, output logic [40:0] e, output int hidx);
        logic [2:0] seg = va[31:29];
        hidx = -1;
        e = '0;
        if (!req) return;
        if (seg == 3'b100 || seg == 3'b101) begin
            e = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, seg[0], 3'b000, 3'b000, va[28:0]};
            return;
        end
        for (int i = 63; i >= 0; i--)
            if (m_v[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) hidx = i;
        if (hidx < 0)
            e = {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 32'h0};
        else if (wr && !m_rw[hidx]) begin
            e = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 32'h0};
            hidx = -1;
        end else
            e = {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, m_d[hidx], m_r[hidx], m_rw[hidx],
                 m_ppn[hidx], va[11:0]};
    endtask

    // One cycle: optional lookup and optional refill, then compare and update the model.
    task automatic step(input logic req, input logic [31:0] va, input logic [5:0] asid,
                        input logic wr, input logic wen, input int widx,
                        input logic [19:0] vpn, input logic [19:0] ppn, input logic [5:0] wasid,
                        input logic v, input logic d, input logic rw, input string tag);
        logic [40:0] e, got;
        int hidx;
        @(negedge clk);
        lk_req = req; lk_vaddr = va; lk_asid = asid; lk_write = wr;
        wr_en = wen; wr_idx = 6'(widx); wr_vpn = vpn; wr_ppn = ppn; wr_asid = wasid;
        wr_valid = v; wr_dirty = d; wr_rw = rw;
        expect_rsp(req, va, asid, wr, e, hidx);
        @(posedge clk); #1;
        got = {rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_mapped, rsp_uncached,
               rsp_dirty, rsp_ref, rsp_rw, rsp_paddr};
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, e);
        end
        if (hidx >= 0) m_r[hidx] = 1'b1;
        if (wen) begin
            m_vpn[widx] = vpn; m_ppn[widx] = ppn; m_asid[widx] = wasid;
            m_v[widx] = v; m_d[widx] = d; m_r[widx] = 1'b0; m_rw[widx] = rw;
        end
        lk_req = 0; wr_en = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic wr,
                        input string tag);
        step(1, va, asid, wr, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [5:0] asid, input logic d, input logic rw);
        step(0, 0, 0, 0, 1, idx, vpn, ppn, asid, 1, d, rw, "R12");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_vpn[i] = 0; m_ppn[i] = 0; m_asid[i] = 0;
            m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_rw[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got %b expected 0", rsp_valid);
        end
        look(32'h0000_5123, 6'd0, 0, "R1");                     // empty buffer misses
        fill(5, 20'h00012, 20'hABCDE, 6'd3, 1, 1);
        look(32'h0001_2345, 6'd3, 0, "R4");                     // R2 hit, first ref=0
        look(32'h0001_2FFF, 6'd3, 1, "R6");                     // ref now 1, write allowed
        look(32'h0001_2000, 6'd4, 0, "R3");                     // other tag misses
        fill(9, 20'h00012, 20'h11111, 6'd4, 0, 1);
        look(32'h0001_2ABC, 6'd4, 0, "R3");
        look(32'h0001_2ABC, 6'd3, 0, "R3");
        fill(20, 20'h00777, 20'h22222, 6'd1, 0, 1);
        fill(2, 20'h00777, 20'h33333, 6'd1, 1, 0);
        look(32'h0077_7010, 6'd1, 0, "R5");                     // slot 2 wins
        fill(30, 20'h00500, 20'h44444, 6'd2, 0, 0);
        look(32'h0050_0008, 6'd2, 1, "R7");                     // store to read-only
        look(32'h0050_0008, 6'd2, 0, "R7");                     // ref still 0
        look(32'h0050_0008, 6'd2, 0, "R6");                     // ref now 1
        fill(31, 20'h80001, 20'h55555, 6'd0, 1, 1);
        look(32'h8000_1234, 6'd0, 0, "R8");                     // bypass despite entry
        look(32'hA123_4567, 6'd0, 1, "R9");
        fill(32, 20'hC0010, 20'h66666, 6'd5, 0, 1);
        look(32'hC001_0ABC, 6'd5, 0, "R10");
        look(32'h7FFF_F000, 6'd5, 0, "R10");
        step(1, 32'h0040_0100, 6'd7, 0, 1, 40, 20'h00400, 20'h77777, 6'd7, 1, 0, 1, "R11");
        look(32'h0040_0100, 6'd7, 0, "R11");
        step(0, 32'h0040_0100, 6'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
        fill(3, 20'h00012, 20'h0, 6'd3, 0, 1);
        step(1, 32'h0001_2000, 6'd3, 0, 1, 3, 20'h00012, 20'h0, 6'd3, 0, 0, 1, "R11");
        look(32'h0001_2000, 6'd3, 0, "R11");                    // invalidated slot 3, slot 5 hits

        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            logic [2:0] segs [6] = '{3'b000, 3'b011, 3'b110, 3'b111, 3'b100, 3'b101};
            logic [19:0] vpn = {segs[$urandom % 6], 17'($urandom % 6)};
            logic [5:0] asid = 6'($urandom % 3);
            int r = $urandom % 4;
            if (r == 0)
                step($urandom % 2 == 0, {vpn, 12'($urandom)}, asid, 1'($urandom), 1,
                     $urandom % 64, vpn, 20'($urandom), asid, ($urandom % 8) != 0,
                     1'($urandom), 1'($urandom), "R11");
            else if (r == 1)
                step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
            else
                look({vpn, 12'($urandom)}, asid, 1'($urandom), "R2");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule